// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block is a byte-wide serial port in which transmitter and receiver share a single shift clock. A CPU reaches it through four register addresses on a simple bus. Writing the data address queues a byte for transmission and starts a transfer. Reading the same address returns the last byte that was received. Data leaves on `sdo` and arrives on `sdi`, least significant bit first. The output bit changes on the falling edge of the shift clock, and the input bit is sampled on the rising edge. Every transfer moves one byte out and one byte in at the same time.

The shift clock has two sources. With the internal clock selected, a reloadable down-counter divides either the system clock or the system clock divided by four by (n+1). A toggle stage then halves that rate, and the result is driven out on `sclk_o` with `sclk_oe` asserted. With the internal clock not selected, `sclk_i` is brought through a synchroniser and its edges clock the shifters. The shift clock idles high.

A second byte written before the current one finishes is loaded as soon as the eighth bit ends, so the clock runs on without a gap. The block also has a transmit interrupt whose source can be selected, a receive interrupt, an overrun flag and a receive-ready handshake output.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, status reads 0x05 (TBE and TSC set, RBF and overrun clear). `sdo` and `sclk_o` are high. `tx_irq`, `rx_irq` and `rx_ready` are low.
- R2: The register addresses are: 0 data (a write fills the transmit buffer, a read returns the receive buffer), 1 status, 2 control, 3 divider reload. Status holds overrun in bit 3, TSC in bit 2, RBF in bit 1 and TBE in bit 0. Control holds sync enable in bit 6, receive enable in bit 3, transmit-interrupt source in bit 2 (1 = TSC), divide-by-four prescale in bit 1 and internal clock in bit 0. Control and reload read back as written, and `rdata` follows `addr` combinationally.
- R3: A data write clears TBE. TBE sets again, and TSC clears, in the cycle the byte moves into the shift register. TSC sets after the eighth rising edge if no byte is waiting.
- R4: With the internal clock, every half period of `sclk_o` lasts (n+1) cycles, or 4·(n+1) cycles with the prescale bit set, where n is the reload value. `sclk_o` is high whenever no transfer is running.
- R5: Bits leave on `sdo` least significant first and change on the falling edges of the shift clock. `sdi` is sampled on the rising edges.
- R6: A byte written while the current shift is still running follows with no gap. For two bytes, the time from the first falling edge to the last rising edge is exactly 31 half periods.
- R7: RBF sets when the eighth bit is received, and the receive buffer then holds the byte. A read of the data address clears RBF.
- R8: A byte that completes while RBF is still set sets overrun and replaces the buffer contents. A read of the status address clears overrun.
- R9: `tx_irq` equals TBE or TSC, as selected by control bit 2. `rx_irq` equals RBF. Both are low while sync enable is clear.
- R10: With the internal clock not selected, `sclk_oe` is low and the shifters follow the edges of `sclk_i` after two synchroniser stages.
- R11: `rx_ready` is high when sync and receive are enabled, RBF is clear and no byte is in progress. It drops at the first falling edge of a byte.
- R12: While sync enable is clear, no transfer starts or advances, even when a byte has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears flags on read) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on `bus_addr` |
| sclk_i | input | 1 | External shift clock |
| sclk_o | output | 1 | Internal shift clock, idles high |
| sclk_oe | output | 1 | High when the internal clock drives the line |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| rx_ready | output | 1 | Receive-ready handshake |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The divider-period and frozen-state assertions assume that the control and reload registers are not rewritten while a byte is shifting. They also assume that an external `sclk_i` stays in each level for several system clocks, so that the synchroniser sees every edge. The stimulus follows both rules. It reprograms the port only after TSC is set, and it holds each level of the external clock for six cycles. It also changes `sdi` only while the external clock is low, well away from the delayed rising edge that samples it.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam logic [1:0] ADR_DATA   = 2'd0;
  localparam logic [1:0] ADR_STATUS = 2'd1;
  localparam logic [1:0] ADR_CTRL   = 2'd2;
  localparam logic [1:0] ADR_RELOAD = 2'd3;

  localparam int CTL_INTCLK = 0;
  localparam int CTL_QUART  = 1;
  localparam int CTL_TXSRC  = 2;
  localparam int CTL_RXEN   = 3;
  localparam int CTL_SYNC   = 6;

  // cycles per half shift-clock period
  function automatic int unsigned half_period(logic [15:0] n, logic quarter, int pre_w);
    int unsigned scale;
    scale = quarter ? (32'd1 << pre_w) : 32'd1;
    return (32'(n) + 32'd1) * scale;
  endfunction
endpackage

// File: rtl/sio_baud_gen.sv
module sio_baud_gen #(
  parameter int DIV_W = 8,
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             quarter,
  input  logic [DIV_W-1:0] reload,
  output logic             fall_o,
  output logic             rise_o,
  output logic             sclk_o
);
  import sio_pkg::*;

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             pre_tick, tick;

  assign pre_tick = quarter ? (pre_q == '1) : 1'b1;
  assign tick     = run && pre_tick && (cnt_q == '0);
  assign fall_o   = tick && sclk_q;
  assign rise_o   = tick && !sclk_q;
  assign sclk_o   = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (!run) begin
      pre_q  <= '0;
      cnt_q  <= reload;
      sclk_q <= 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (pre_tick) cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
      if (tick) sclk_q <= ~sclk_q;
    end
  end

  // cycle count since run began or since the previous tick
  logic [31:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= 32'd1;
    else if (!run)   gap_q <= 32'd1;
    else if (tick)   gap_q <= 32'd1;
    else             gap_q <= gap_q + 32'd1;
  end

  // R4
  half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> gap_q == half_period(16'(reload), quarter, PRE_W));
endmodule

// File: rtl/sio_edge_det.sv
module sio_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall_o,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;
  logic                   synced;

  assign synced = chain_q[SYNC_STAGES-1];
  assign fall_o = prev_q && !synced;
  assign rise_o = !prev_q && synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[SYNC_STAGES-2:0], din};
      prev_q  <= synced;
    end
  end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int PRE_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe,
  output logic              sdo,
  input  logic              sdi,
  output logic              rx_ready,
  output logic              tx_irq,
  output logic              rx_irq
);
  import sio_pkg::*;

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] ctrl_q, txbuf_q, txsh_q, rxsh_q, rxbuf_q, rx_next;
  logic [DIV_W-1:0]  reload_q;
  logic [CNT_W-1:0]  bits_q;
  logic tbe_q, tsc_q, rbf_q, ovr_q, inbyte_q, sdo_q;

  logic sync_en, int_clk, quarter, tx_src, rx_en, busy;
  logic wr_data, rd_data, rd_stat;
  logic bg_fall, bg_rise, bg_sclk, ex_fall, ex_rise;
  logic fall_ev, rise_ev, byte_done, load_ev;

  assign sync_en = ctrl_q[CTL_SYNC];
  assign int_clk = ctrl_q[CTL_INTCLK];
  assign quarter = ctrl_q[CTL_QUART];
  assign tx_src  = ctrl_q[CTL_TXSRC];
  assign rx_en   = ctrl_q[CTL_RXEN];
  assign busy    = (bits_q != '0);

  assign wr_data = bus_wr && (bus_addr == ADR_DATA);
  assign rd_data = bus_rd && (bus_addr == ADR_DATA);
  assign rd_stat = bus_rd && (bus_addr == ADR_STATUS);

  sio_baud_gen #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(sync_en && int_clk && busy),
    .quarter(quarter), .reload(reload_q),
    .fall_o(bg_fall), .rise_o(bg_rise), .sclk_o(bg_sclk)
  );

  sio_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(sclk_i),
    .fall_o(ex_fall), .rise_o(ex_rise)
  );

  // named shift events
  assign fall_ev   = sync_en && busy && (int_clk ? bg_fall : ex_fall);
  assign rise_ev   = sync_en && busy && (int_clk ? bg_rise : ex_rise);
  assign byte_done = rise_ev && (bits_q == CNT_W'(1));
  assign load_ev   = sync_en && !tbe_q && (!busy || byte_done);
  assign rx_next   = {sdi, rxsh_q[DATA_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      txbuf_q  <= '0;
      txsh_q   <= '0;
      rxsh_q   <= '0;
      rxbuf_q  <= '0;
      bits_q   <= '0;
      tbe_q    <= 1'b1;
      tsc_q    <= 1'b1;
      rbf_q    <= 1'b0;
      ovr_q    <= 1'b0;
      inbyte_q <= 1'b0;
      sdo_q    <= 1'b1;
    end else begin
      if (bus_wr && bus_addr == ADR_CTRL)   ctrl_q   <= bus_wdata;
      if (bus_wr && bus_addr == ADR_RELOAD) reload_q <= DIV_W'(bus_wdata);
      if (fall_ev) begin
        sdo_q    <= txsh_q[0];
        inbyte_q <= 1'b1;
      end
      if (rise_ev) begin
        rxsh_q <= rx_next;
        txsh_q <= txsh_q >> 1;
        bits_q <= bits_q - CNT_W'(1);
      end
      if (byte_done) begin
        rxbuf_q  <= rx_next;
        inbyte_q <= 1'b0;
        if (!load_ev) tsc_q <= 1'b1;
      end
      if (load_ev) begin
        txsh_q <= txbuf_q;
        bits_q <= CNT_W'(DATA_W);
        tbe_q  <= 1'b1;
        tsc_q  <= 1'b0;
      end
      if (wr_data) begin
        txbuf_q <= bus_wdata;
        tbe_q   <= 1'b0;
      end
      if (rd_data)   rbf_q <= 1'b0;
      if (byte_done) rbf_q <= 1'b1;
      if (rd_stat)   ovr_q <= 1'b0;
      if (byte_done && rbf_q) ovr_q <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      ADR_DATA:   bus_rdata = rxbuf_q;
      ADR_STATUS: bus_rdata = {{(DATA_W-4){1'b0}}, ovr_q, tsc_q, rbf_q, tbe_q};
      ADR_CTRL:   bus_rdata = ctrl_q;
      default:    bus_rdata = DATA_W'(reload_q);
    endcase
  end

  assign sclk_o   = bg_sclk;
  assign sclk_oe  = sync_en && int_clk;
  assign sdo      = sdo_q;
  assign rx_ready = sync_en && rx_en && !rbf_q && !inbyte_q;
  assign tx_irq   = sync_en && (tx_src ? tsc_q : tbe_q);
  assign rx_irq   = sync_en && rbf_q;

  // R3
  tbe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> !tbe_q);
  // R7
  rbf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> rbf_q);
  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && rbf_q) |=> ovr_q);
  // R4
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_o);
  // R12
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |=> $stable(bits_q));
  // R11
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !rbf_q);
endmodule

// File: tb/sync_serial_port_tb.sv
module sync_serial_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0] addr = 2'd0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'd0;
  wire  [7:0] rdata;
  logic sclk_in = 1'b1, sdi_drv = 1'b1, loop = 1'b0;
  wire  sclk_out, sclk_oe, sdo, rx_ready, tx_irq, rx_irq;
  wire  sdi = loop ? sdo : sdi_drv;

  sync_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .sclk_i(sclk_in), .sclk_o(sclk_out),
    .sclk_oe(sclk_oe), .sdo(sdo), .sdi(sdi), .rx_ready(rx_ready),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  int vectors = 0, miscmp = 0, cyc = 0;

  task automatic eq(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscmp++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_ctrl, m_reload, m_txbuf, m_txsh, m_rxacc, m_rxbuf, m_bits, m_wait;
  bit m_tbe, m_tsc, m_rbf, m_ovr, m_inbyte, m_sdo, m_sclk, h1, h2, h3;
  bit rxd_cap = 1'b1;

  function automatic int half_cycles();
    return (m_reload + 1) * (m_ctrl[1] ? 4 : 1);
  endfunction

  always @(negedge clk) begin
    #1 rxd_cap = sdi;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_reload = 0; m_txbuf = 0; m_txsh = 0; m_rxacc = 0;
      m_rxbuf = 0; m_bits = 0; m_wait = 0;
      m_tbe = 1; m_tsc = 1; m_rbf = 0; m_ovr = 0; m_inbyte = 0;
      m_sdo = 1; m_sclk = 1; h1 = 1; h2 = 1; h3 = 1;
    end else begin
      bit sync, busy, f, r, done, load, old_rbf;
      sync = m_ctrl[6];
      busy = (m_bits > 0);
      f = 0; r = 0;
      if (sync && busy) begin
        if (m_ctrl[0]) begin
          m_wait--;
          if (m_wait == 0) begin
            m_wait = half_cycles();
            if (m_sclk) f = 1; else r = 1;
            m_sclk = !m_sclk;
          end
        end else begin
          f = h3 && !h2;
          r = !h3 && h2;
        end
      end
      h3 = h2; h2 = h1; h1 = sclk_in;
      done = r && (m_bits == 1);
      load = sync && !m_tbe && (!busy || done);
      old_rbf = m_rbf;
      if (f) begin m_sdo = m_txsh[0]; m_inbyte = 1; end
      if (r) begin
        m_rxacc = (m_rxacc >> 1) | (int'(rxd_cap) << 7);
        m_txsh  = m_txsh >> 1;
        m_bits--;
      end
      if (done) begin
        m_rxbuf = m_rxacc; m_inbyte = 0;
        if (!load) m_tsc = 1;
      end
      if (load) begin
        m_txsh = m_txbuf; m_bits = 8; m_tbe = 1; m_tsc = 0;
        if (!busy) m_wait = half_cycles();
      end
      if (wr) begin
        case (addr)
          2'd0: begin m_txbuf = wdata; m_tbe = 0; end
          2'd2: m_ctrl = wdata;
          2'd3: m_reload = wdata;
          default: ;
        endcase
      end
      if (rd && addr == 2'd0) m_rbf = 0;
      if (done) m_rbf = 1;
      if (rd && addr == 2'd1) m_ovr = 0;
      if (done && old_rbf) m_ovr = 1;
    end
  end

  // per-clock comparison and shift-clock monitor
  int falls = 0, first_fall = 0, last_fall = 0, last_rise = 0, first_low = -1;
  bit prev_s = 1'b1;

  task automatic mon_clear();
    falls = 0; first_low = -1;
  endtask

  always @(posedge clk) begin
    int exp_rd;
    #2;
    cyc++;
    case (addr)
      2'd0: exp_rd = m_rxbuf;
      2'd1: exp_rd = {m_ovr, m_tsc, m_rbf, m_tbe};
      2'd2: exp_rd = m_ctrl;
      default: exp_rd = m_reload;
    endcase
    eq("R5 sdo", sdo, m_sdo);
    eq("R4 sclk_o", sclk_out, m_sclk);
    eq("R10 sclk_oe", sclk_oe, m_ctrl[6] && m_ctrl[0]);
    eq("R9 tx_irq", tx_irq, m_ctrl[6] && (m_ctrl[2] ? m_tsc : m_tbe));
    eq("R9 rx_irq", rx_irq, m_ctrl[6] && m_rbf);
    eq("R11 rx_ready", rx_ready, m_ctrl[6] && m_ctrl[3] && !m_rbf && !m_inbyte);
    eq("R2 rdata", rdata, exp_rd);
    if (prev_s && !sclk_out) begin
      if (falls == 0) first_fall = cyc;
      falls++; last_fall = cyc;
    end
    if (!prev_s && sclk_out) begin
      last_rise = cyc;
      if (first_low < 0) first_low = cyc - last_fall;
    end
    prev_s = sclk_out;
    if (cyc > 100000) begin
      miscmp++;
      $display("FAIL watchdog: actual cycles=%0d expected below 100000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_stat(logic [7:0] mask, logic [7:0] val);
    logic [7:0] s;
    for (int i = 0; i < 20000; i++) begin
      peek(2'd1, s);
      if ((s & mask) == val) break;
    end
  endtask

  task automatic ext_bit(bit b);
    @(negedge clk); sclk_in = 1'b0; sdi_drv = b;
    repeat (6) @(negedge clk);
    sclk_in = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek(2'd1, d); eq("R1 status", d, 8'h05);
    eq("R1 sdo", sdo, 1); eq("R1 sclk_o", sclk_out, 1);
    eq("R1 tx_irq", tx_irq, 0); eq("R1 rx_irq", rx_irq, 0); eq("R1 rx_ready", rx_ready, 0);

    // R2 register readback
    bus_write(2'd2, 8'h47); peek(2'd2, d); eq("R2 ctrl", d, 8'h47);
    bus_write(2'd3, 8'h03); peek(2'd3, d); eq("R2 reload", d, 8'h03);

    // R12 sync disabled: a written byte waits
    bus_write(2'd2, 8'h01);
    bus_write(2'd0, 8'h5A);
    repeat (40) @(negedge clk);
    peek(2'd1, d); eq("R12 status (R3 TBE clear)", d, 8'h04);
    eq("R12 sclk_o", sclk_out, 1); eq("R12 sdo", sdo, 1);

    // R4 R5 R7 single byte, internal clock, loopback
    loop = 1'b1; mon_clear();
    bus_write(2'd2, 8'h49);
    repeat (3) @(negedge clk);
    wait_stat(8'h04, 8'h04);
    eq("R4 low half period", first_low, 4);
    eq("R5 falling edges per byte", falls, 8);
    eq("R9 rx_irq after byte", rx_irq, 1);
    bus_read(2'd0, d); eq("R7 received byte", d, 8'h5A);
    peek(2'd1, d); eq("R7 RBF cleared by read", d, 8'h05);
    bus_write(2'd2, 8'h4D);
    eq("R9 tx_irq from TSC", tx_irq, 1);

    // R6 R8 back-to-back bytes with prescale
    bus_write(2'd3, 8'h01);
    bus_write(2'd2, 8'h4B);
    mon_clear();
    bus_write(2'd0, 8'h81);
    repeat (3) @(negedge clk);
    wait_stat(8'h01, 8'h01);
    peek(2'd1, d); eq("R3 TBE set, TSC clear on load", d & 8'h05, 8'h01);
    eq("R9 tx_irq from TBE", tx_irq, 1);
    bus_write(2'd0, 8'h7E);
    repeat (3) @(negedge clk);
    wait_stat(8'h04, 8'h04);
    eq("R6 falling edges", falls, 16);
    eq("R6 gap-free span", last_rise - first_fall, 31 * 8);
    peek(2'd1, d); eq("R8 overrun set", d, 8'h0F);
    bus_read(2'd0, d); eq("R8 buffer replaced", d, 8'h7E);
    bus_read(2'd1, d);
    peek(2'd1, d); eq("R8 overrun cleared", d, 8'h05);

    // R10 R11 external clock receive
    loop = 1'b0;
    bus_write(2'd2, 8'h48);
    eq("R10 sclk_oe low", sclk_oe, 0);
    eq("R11 ready idle", rx_ready, 1);
    bus_write(2'd0, 8'h00);
    repeat (4) @(negedge clk);
    eq("R11 ready before first edge", rx_ready, 1);
    for (int i = 0; i < 8; i++) begin
      ext_bit(i inside {1, 2, 6, 7});
      if (i == 0) eq("R11 ready dropped in byte", rx_ready, 0);
    end
    repeat (4) @(negedge clk);
    eq("R11 ready low with RBF", rx_ready, 0);
    bus_read(2'd0, d); eq("R10 external-clock byte", d, 8'hC6);
    @(negedge clk);
    eq("R11 ready after read", rx_ready, 1);

    repeat (4) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule